// File: doc/BRIEF.md
# VGA Sequencer and Graphics Register File

This block holds the two indexed register banks of a standard VGA: the sequencer bank and the graphics-controller bank. Each bank is reached through a pair of I/O ports. A byte written to the even port of the pair selects a register. A byte written to the odd port stores into the register selected last. Each stored byte is masked so that reserved bits always read back as zero. Every register value is driven out in parallel to the video memory datapath.

A port write carries one or two bytes. A two-byte write is handled as two byte writes in one clock. The low byte goes to the addressed port, then the high byte goes to the next port. This lets a single access set an index and store its data. Writes are always accepted, so the write channel has no back-pressure: any cycle with `wr_valid` high is a write. One cycle later, `wr_handled` reports whether every byte of the access reached a decoded port with a usable index.

The block also keeps a standard-mode flag, which is true when sequencer register 7 is zero. This flag drives a three-state cache-permission machine. The first rising edge of the flag grants the cache. A later disable request withdraws it for good.

Top module: `vga_regfile`

## Requirements
- R1: After synchronous reset every register of both banks and both index latches are zero, `wr_handled` is 0, `std_mode` is 0 and `cache_state` is 0 (cold).
- R2: A byte to port 0x03C4 (sequencer) or 0x03CE (graphics) latches the index. A byte to 0x03C5 or 0x03CF stores to the register of the latched index. Each such access gives `wr_handled` = 1 in the cycle after the write.
- R3: Sequencer register i keeps only the bits set in this keep mask, listed for i = 0..7: 0x03, 0x3D, 0x0F, 0x3F, 0x0E, 0x00, 0x00, 0xFF. All other bits are stored as zero.
- R4: Graphics register i keeps only the bits set in this keep mask, listed for i = 0..8: 0x0F, 0x0F, 0x0F, 0x1F, 0x03, 0x7B, 0x0F, 0x0F, 0xFF.
- R5: A data byte is dropped when the latched index is 8 or more for the sequencer, or 9 or more for the graphics bank. The access then reports `wr_handled` = 0.
- R6: A byte to any other port changes no register and reports `wr_handled` = 0.
- R7: With `wr_size` = 2, the low byte (bits 7:0) goes to `wr_port` and then the high byte (bits 15:8) goes to `wr_port`+1, both in the same cycle. `wr_handled` is 1 only if both bytes were accepted. A byte that is accepted is kept even when its partner is rejected.
- R8: Only `wr_size` values 1 and 2 are legal. With any other size the write changes nothing and reports `wr_handled` = 0.
- R9: After every write of legal size, `std_mode` equals (sequencer register 7 == 0x00).
- R10: `cache_state` moves from 0 (cold) to 1 (enabled) only when `std_mode` rises during a write. This includes a rise after the first byte that is undone by the second byte. A rise in any other state changes nothing.
- R11: `cache_disable_req` moves `cache_state` from 1 to 2 (disabled). State 2 is never left except by reset. The request acts on the state held at the start of the cycle and does nothing in states 0 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Port write present this cycle (always accepted) |
| wr_port | input | 16 | I/O port address of the first byte |
| wr_size | input | 2 | Bytes in the access: 1 or 2 |
| wr_data | input | 16 | Write bytes, low byte first |
| cache_disable_req | input | 1 | Request to withdraw cache permission |
| wr_handled | output | 1 | One-cycle result for the previous cycle's write |
| seq_regs | output | 64 | Sequencer registers, register i at bits 8i+7:8i |
| gfx_regs | output | 72 | Graphics registers, register i at bits 8i+7:8i |
| std_mode | output | 1 | Standard-mode flag |
| cache_state | output | 2 | 0 cold, 1 enabled, 2 disabled |

## Verification
Some properties are checked on every cycle. Reserved bits stay zero in both banks. The banks hold still when no byte lane is active. Illegal sizes never report handled. `std_mode` tracks sequencer register 7 after each write. The cache state only moves forward along cold, enabled, disabled. Other behaviour needs the bench's scenarios: exact masked values per index, the order of the two bytes in a two-byte write, partial acceptance, dropping of out-of-range indices, and a rise of the flag that the second byte cancels.

// File: rtl/vga_rf_pkg.sv
`timescale 1ns/1ps
package vga_rf_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEQ_N   = 8;
  localparam int GFX_N   = 9;
  localparam int STD_IDX = 7;
  localparam int LANES   = 2;
  localparam int PORT_W  = 16;
  localparam logic [PORT_W-1:0] SEQ_BASE = 16'h03C4;
  localparam logic [PORT_W-1:0] GFX_BASE = 16'h03CE;
  // keep masks, register 0 in the low byte
  localparam logic [SEQ_N*BYTE_W-1:0] SEQ_KEEP =
    {8'hFF, 8'h00, 8'h00, 8'h0E, 8'h3F, 8'h0F, 8'h3D, 8'h03};
  localparam logic [GFX_N*BYTE_W-1:0] GFX_KEEP =
    {8'hFF, 8'h0F, 8'h0F, 8'h7B, 8'h03, 8'h1F, 8'h0F, 8'h0F, 8'h0F};
  typedef enum logic [1:0] {CACHE_COLD = 2'd0, CACHE_ON = 2'd1, CACHE_OFF = 2'd2} cache_state_e;
endpackage

// File: rtl/vga_rf_bank.sv
`timescale 1ns/1ps
module vga_rf_bank
  import vga_rf_pkg::*;
#(
  parameter logic [PORT_W-1:0] BASE = 16'h03C4,
  parameter int N = 8,
  parameter logic [N*BYTE_W-1:0] KEEP = '1
)(
  input  logic clk,
  input  logic rst,
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0][PORT_W-1:0] lane_port,
  input  logic [LANES-1:0][BYTE_W-1:0] lane_byte,
  output logic [LANES-1:0] lane_hit,
  output logic [N*BYTE_W-1:0] regs_mid,
  output logic [N*BYTE_W-1:0] regs_next,
  output logic [N*BYTE_W-1:0] regs_q
);
  localparam logic [PORT_W-1:0] DATA_PORT = BASE + 16'd1;
  localparam logic [BYTE_W-1:0] LIMIT = BYTE_W'(N);

  logic [BYTE_W-1:0] idx_q, idx_n;

  always_comb begin
    idx_n     = idx_q;
    regs_next = regs_q;
    regs_mid  = regs_q;
    lane_hit  = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_en[l]) begin
        if (lane_port[l] == BASE) begin
          idx_n = lane_byte[l];
          lane_hit[l] = 1'b1;
        end else if (lane_port[l] == DATA_PORT && idx_n < LIMIT) begin
          for (int i = 0; i < N; i++)
            if (idx_n == BYTE_W'(i))
              regs_next[i*BYTE_W +: BYTE_W] = lane_byte[l] & KEEP[i*BYTE_W +: BYTE_W];
          lane_hit[l] = 1'b1;
        end
      end
      if (l == 0) regs_mid = regs_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      regs_q <= '0;
    end else begin
      idx_q  <= idx_n;
      regs_q <= regs_next;
    end
  end

  a_r3_r4_reserved_clear: assert property (@(posedge clk) disable iff (rst)
    (regs_q & ~KEEP) == '0);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (lane_en == '0) |=> $stable(regs_q));
endmodule

// File: rtl/vga_rf_cache.sv
`timescale 1ns/1ps
module vga_rf_cache
  import vga_rf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enter_req,
  input  logic leave_req,
  output cache_state_e state_q
);
  always_ff @(posedge clk) begin
    if (rst) state_q <= CACHE_COLD;
    else begin
      unique case (state_q)
        CACHE_COLD: if (enter_req) state_q <= CACHE_ON;
        CACHE_ON:   if (leave_req) state_q <= CACHE_OFF;
        default:    state_q <= CACHE_OFF;
      endcase
    end
  end

  a_r11_off_terminal: assert property (@(posedge clk) disable iff (rst)
    state_q == CACHE_OFF |=> state_q == CACHE_OFF);
  a_r10_cold_needs_rise: assert property (@(posedge clk) disable iff (rst)
    (state_q == CACHE_COLD && !enter_req) |=> state_q == CACHE_COLD);
  a_r11_on_forward_only: assert property (@(posedge clk) disable iff (rst)
    state_q == CACHE_ON |=> state_q != CACHE_COLD);
endmodule

// File: rtl/vga_regfile.sv
`timescale 1ns/1ps
module vga_regfile
  import vga_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_valid,
  input  logic [15:0] wr_port,
  input  logic [1:0]  wr_size,
  input  logic [15:0] wr_data,
  input  logic        cache_disable_req,
  output logic        wr_handled,
  output logic [63:0] seq_regs,
  output logic [71:0] gfx_regs,
  output logic        std_mode,
  output logic [1:0]  cache_state
);
  logic size_ok;
  logic [LANES-1:0] lane_en, seq_hit, gfx_hit, any_hit;
  logic [LANES-1:0][PORT_W-1:0] lane_port;
  logic [LANES-1:0][BYTE_W-1:0] lane_byte;
  logic [SEQ_N*BYTE_W-1:0] seq_mid, seq_next;
  logic [GFX_N*BYTE_W-1:0] gfx_mid, gfx_next;
  logic mid_zero, next_zero, all_hit, std_rise;
  cache_state_e cstate;

  assign size_ok = (wr_size == 2'd1) || (wr_size == 2'd2);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l]   = wr_valid && (l == 0 ? size_ok : (wr_size == 2'd2));
    assign lane_port[l] = wr_port + PORT_W'(l);
    assign lane_byte[l] = wr_data[l*BYTE_W +: BYTE_W];
    assign any_hit[l]   = seq_hit[l] | gfx_hit[l];
  end

  vga_rf_bank #(.BASE(SEQ_BASE), .N(SEQ_N), .KEEP(SEQ_KEEP)) u_seq (
    .clk(clk), .rst(rst), .lane_en(lane_en), .lane_port(lane_port),
    .lane_byte(lane_byte), .lane_hit(seq_hit), .regs_mid(seq_mid),
    .regs_next(seq_next), .regs_q(seq_regs));

  vga_rf_bank #(.BASE(GFX_BASE), .N(GFX_N), .KEEP(GFX_KEEP)) u_gfx (
    .clk(clk), .rst(rst), .lane_en(lane_en), .lane_port(lane_port),
    .lane_byte(lane_byte), .lane_hit(gfx_hit), .regs_mid(gfx_mid),
    .regs_next(gfx_next), .regs_q(gfx_regs));

  assign mid_zero  = seq_mid[STD_IDX*BYTE_W +: BYTE_W] == '0;
  assign next_zero = seq_next[STD_IDX*BYTE_W +: BYTE_W] == '0;
  assign all_hit   = any_hit[0] && (!lane_en[1] || any_hit[1]);
  // rise after the first byte, or after the second if the first left it low
  assign std_rise  = lane_en[0] &&
                     ((!std_mode && mid_zero) || (lane_en[1] && !mid_zero && next_zero));

  vga_rf_cache u_cache (
    .clk(clk), .rst(rst), .enter_req(std_rise), .leave_req(cache_disable_req),
    .state_q(cstate));
  assign cache_state = cstate;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_handled <= 1'b0;
      std_mode   <= 1'b0;
    end else begin
      wr_handled <= lane_en[0] && all_hit;
      if (lane_en[0]) std_mode <= next_zero;
    end
  end

  a_r2_handled_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_handled |-> $past(wr_valid));
  a_r8_bad_size_unhandled: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !size_ok) |=> !wr_handled);
  a_r9_std_tracks_reg7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && size_ok) |=> std_mode == (seq_regs[STD_IDX*BYTE_W +: BYTE_W] == 8'h00));
endmodule

// File: tb/vga_regfile_tb_top.sv
`timescale 1ns/1ps
module vga_regfile_tb_top;
  logic clk = 0, rst = 1, wr_valid = 0, cache_disable_req = 0;
  logic [15:0] wr_port = '0, wr_data = '0;
  logic [1:0] wr_size = '0;
  logic wr_handled, std_mode;
  logic [63:0] seq_regs;
  logic [71:0] gfx_regs;
  logic [1:0] cache_state;

  always #2.5 clk = ~clk;

  vga_regfile dut_i (.*);

  typedef struct {
    bit h; bit s; logic [1:0] c; logic [63:0] sq; logic [71:0] gf; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;

  // model
  logic [7:0] seq_m [8];
  logic [7:0] gfx_m [9];
  logic [7:0] sidx_m, gidx_m;
  bit std_m, rise_m;
  logic [1:0] cache_m;
  logic [7:0] sres [8] = '{8'hFC, 8'hC2, 8'hF0, 8'hC0, 8'hF1, 8'hFF, 8'hFF, 8'h00};
  logic [7:0] gres [9] = '{8'hF0, 8'hF0, 8'hF0, 8'hE0, 8'hFC, 8'h84, 8'hF0, 8'hF0, 8'h00};

  task automatic chk(bit ok, string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) seq_m[i] = '0;
    for (int i = 0; i < 9; i++) gfx_m[i] = '0;
    sidx_m = '0; gidx_m = '0; std_m = 0; cache_m = 2'd0;
  endtask

  task automatic mbyte(input logic [15:0] p, input logic [7:0] b, output bit hit);
    bit s_new;
    hit = 0;
    if (p == 16'h03C4) begin sidx_m = b; hit = 1; end
    else if (p == 16'h03C5) begin
      if (sidx_m < 8) begin seq_m[sidx_m] = b & ~sres[sidx_m]; hit = 1; end
    end else if (p == 16'h03CE) begin gidx_m = b; hit = 1; end
    else if (p == 16'h03CF) begin
      if (gidx_m < 9) begin gfx_m[gidx_m] = b & ~gres[gidx_m]; hit = 1; end
    end
    s_new = (seq_m[7] == 8'h00);
    if (!std_m && s_new) rise_m = 1;
    std_m = s_new;
  endtask

  function automatic logic [63:0] seq_flat();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = seq_m[i];
    return v;
  endfunction
  function automatic logic [71:0] gfx_flat();
    logic [71:0] v;
    for (int i = 0; i < 9; i++) v[i*8 +: 8] = gfx_m[i];
    return v;
  endfunction

  // driver: one write, expected result pushed to the scoreboard
  task automatic do_wr(input logic [15:0] p, input logic [1:0] sz, input logic [15:0] d, input string tag);
    exp_t e;
    bit h0, h1;
    logic [1:0] c0;
    @(negedge clk);
    wr_valid = 1; wr_port = p; wr_size = sz; wr_data = d;
    c0 = cache_m; rise_m = 0; h0 = 0; h1 = 1;
    if (sz == 2'd1 || sz == 2'd2) begin
      mbyte(p, d[7:0], h0);
      if (sz == 2'd2) mbyte(p + 16'd1, d[15:8], h1);
    end
    if (rise_m && c0 == 2'd0) cache_m = 2'd1;
    e.h = h0 && h1; e.s = std_m; e.c = cache_m;
    e.sq = seq_flat(); e.gf = gfx_flat(); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    wr_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_dis(input string tag);
    @(negedge clk);
    cache_disable_req = 1;
    if (cache_m == 2'd1) cache_m = 2'd2;
    @(negedge clk);
    cache_disable_req = 0;
    chk(cache_state == cache_m, tag, 72'(cache_state), 72'(cache_m));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    chk(seq_regs == '0 && gfx_regs == '0, "R1 banks clear", 72'(seq_regs ^ gfx_regs[63:0]), 72'(0));
    chk(wr_handled == 0 && std_mode == 0, "R1 flags clear", 72'({wr_handled, std_mode}), 72'(0));
    chk(cache_state == 2'd0, "R1 cache cold", 72'(cache_state), 72'(0));
  endtask

  // monitor: compare results the cycle after each write
  initial begin
    forever begin
      @(posedge clk);
      if (wr_valid && !rst) begin
        exp_t e;
        @(negedge clk);
        e = q.pop_front();
        chk(wr_handled == e.h, {e.tag, " handled"}, 72'(wr_handled), 72'(e.h));
        chk(std_mode == e.s, {e.tag, " R9 std_mode"}, 72'(std_mode), 72'(e.s));
        chk(cache_state == e.c, {e.tag, " cache"}, 72'(cache_state), 72'(e.c));
        chk(seq_regs == e.sq, {e.tag, " seq bank"}, 72'(seq_regs), 72'(e.sq));
        chk(gfx_regs == e.gf, {e.tag, " gfx bank"}, gfx_regs, e.gf);
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    do_wr(16'h03C4, 2'd1, 16'h0002, "R2 R10 first index write");
    do_wr(16'h03C5, 2'd1, 16'h00FF, "R2 R3 seq data");
    for (int i = 0; i < 8; i++) do_wr(16'h03C4, 2'd2, {8'hFF, 8'(i)}, "R3 R7 seq mask sweep");
    do_wr(16'h03C4, 2'd2, 16'h0007, "R10 rise while enabled");
    for (int i = 0; i < 9; i++) do_wr(16'h03CE, 2'd2, {8'hFF, 8'(i)}, "R4 gfx mask sweep");
    do_wr(16'h03CE, 2'd2, 16'hAA09, "R5 gfx index 9");
    do_wr(16'h03C4, 2'd2, 16'h5508, "R5 seq index 8");
    do_wr(16'h03C6, 2'd1, 16'h00FF, "R6 port 3C6");
    do_wr(16'h03D0, 2'd2, 16'hFFFF, "R6 port 3D0");
    do_wr(16'h0000, 2'd1, 16'h0011, "R6 port 0");
    do_wr(16'h03C4, 2'd1, 16'h0001, "R2 seq index 1");
    do_wr(16'h03C5, 2'd2, 16'h77FF, "R7 partial accept");
    do_wr(16'h03CE, 2'd1, 16'h0005, "R2 gfx index 5");
    do_wr(16'h03CF, 2'd2, 16'h12FF, "R7 gfx partial");
    do_wr(16'h03C4, 2'd0, 16'h0003, "R8 size 0");
    do_wr(16'h03C4, 2'd3, 16'h0003, "R8 size 3");
    do_wr(16'h03C5, 2'd1, 16'h0001, "R8 index untouched");
    do_wr(16'h03CE, 2'd2, 16'h3C03, "R4 gfx 3");
    do_dis("R11 disable from enabled");
    do_wr(16'h03C4, 2'd2, 16'hFF07, "R11 std falls");
    do_wr(16'h03C4, 2'd2, 16'h0007, "R11 rise after disable");
    do_dis("R11 disable repeated");
    do_reset();
    do_dis("R11 disable while cold");
    do_wr(16'h03C4, 2'd2, 16'hFF07, "R10 rise cancelled by second byte");
    do_wr(16'h03CF, 2'd1, 16'h00AB, "R2 gfx data index 0");
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "scoreboard drained", 72'(q.size()), 72'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule